// File: doc/BRIEF.md
# Double-Data-Rate Input Capture with Primary-Clock Realignment

This block samples a serial input that carries a new bit on every edge of a receive clock. One register bank takes the pad on the rising edge of the primary clock (the even beat), and a second bank takes it on the rising edge of the complementary clock (the odd beat). The complementary clock normally rises when the primary clock falls.

In cascaded realignment, the odd beat goes through one more register clocked by the primary clock. Both outputs then change only on the primary clock, and the consumer needs a single clock with a full-cycle path. In direct realignment, the odd output comes straight from its complementary-clock register, and the consumer has half a cycle to bring it into the primary domain. Cascaded realignment applies only when the input is differential. If it is requested for a single-ended input, the block falls back to direct behaviour.

A synchronous reset and a clock enable are sampled on the primary clock. They govern the capture on that edge and the complementary-clock capture that follows it, so the two halves of a pair are always cleared or held together. Every pad lane has its own independent capture path.

Top module: `ddr_rx_align`

## Requirements
- R1: When `rst` is high at a primary rising edge, `even_o` is zero after that edge and `odd_o` is zero after the next complementary rising edge. In cascaded mode, `odd_o` is zero after that same primary edge.
- R2: When `rst` is low and `ce` is high at a primary rising edge, `even_o` takes the value `pad_i` had at that edge.
- R3: In direct mode (`MODE` = REALIGN_DIRECT), `odd_o` takes the value `pad_i` had at the complementary rising edge that follows an enabled primary edge. It changes on that complementary edge.
- R4: In cascaded mode (`MODE` = REALIGN_CASCADE with `DIFF_INPUT` = 1), `odd_o` changes only on primary rising edges. On an enabled edge it takes the odd beat captured at the preceding complementary edge, so in one primary cycle the outputs carry beat pair (e_k, o_{k-1}).
- R5: With `MODE` = REALIGN_CASCADE and `DIFF_INPUT` = 0, the block behaves exactly as in direct mode.
- R6: When `ce` is low (and `rst` low) at a primary rising edge, `even_o` and `odd_o` keep their values through that cycle, including across the following complementary edge, whatever `pad_i` does.
- R7: Reset takes priority over a low `ce`: `rst` high with `ce` low still clears the outputs as in R1.
- R8: Bit i of `even_o` and `odd_o` depends only on bit i of `pad_i`. A lone set bit on one lane appears only on that lane of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_p | input | 1 | Primary receive clock; even beats are captured on its rising edge |
| clk_n | input | 1 | Complementary receive clock; odd beats are captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset, sampled on `clk_p` |
| ce | input | 1 | Capture enable, sampled on `clk_p`, gates both phases together |
| pad_i | input | WIDTH | Pad data, one bit per lane |
| even_o | output | WIDTH | Beat captured on the primary rising edge |
| odd_o | output | WIDTH | Beat captured on the complementary rising edge, realigned according to the mode |

## Verification
The bench runs three instances on the same stimulus: cascaded differential, direct, and cascade requested on a single-ended input. Comparing them tells the one-cycle lag of the cascaded odd beat apart from the half-cycle direct path, and shows that the single-ended instance falls back. A counting stream with inverted odd beats shows whether the two phases are swapped or paired with the wrong neighbour. A walking single bit on even beats only, then odd beats only, exposes lane crossover. Enable-low and reset-with-enable-low stretches check that both phases freeze or clear together while the pad keeps changing.

// File: rtl/ddr_rx_pkg.sv
package ddr_rx_pkg;

  typedef enum logic {
    REALIGN_DIRECT  = 1'b0,
    REALIGN_CASCADE = 1'b1
  } realign_e;

endpackage

// File: rtl/ddr_rx_ctl.sv
// Retimes reset and enable on the primary clock so the complementary-clock
// capture that follows an edge obeys the controls sampled at that edge.
module ddr_rx_ctl (
  input  logic clk_p,
  input  logic rst,
  input  logic ce,
  output logic rst_q,
  output logic ce_q
);

  logic rst_r = 1'b1;
  logic ce_r  = 1'b0;

  always_ff @(posedge clk_p) begin
    rst_r <= rst;
    ce_r  <= ce;
  end

  assign rst_q = rst_r;
  assign ce_q  = ce_r;

endmodule

// File: rtl/ddr_rx_edge_reg.sv
// One capture bank: synchronous clear, then enable, on a single clock edge.
module ddr_rx_edge_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (clr)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/ddr_rx_align.sv
module ddr_rx_align #(
  parameter int                   WIDTH      = 4,
  parameter ddr_rx_pkg::realign_e MODE       = ddr_rx_pkg::REALIGN_CASCADE,
  parameter bit                   DIFF_INPUT = 1'b1
) (
  input  logic             clk_p,
  input  logic             clk_n,
  input  logic             rst,
  input  logic             ce,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] even_o,
  output logic [WIDTH-1:0] odd_o
);

  // Cascaded realignment is honoured only on a differential input.
  localparam bit CAS_EFF = (MODE == ddr_rx_pkg::REALIGN_CASCADE) && DIFF_INPUT;

  logic             rst_q;
  logic             ce_q;
  logic [WIDTH-1:0] fall_q;

  ddr_rx_ctl u_ctl (
    .clk_p (clk_p),
    .rst   (rst),
    .ce    (ce),
    .rst_q (rst_q),
    .ce_q  (ce_q)
  );

  // Even beat: primary rising edge.
  ddr_rx_edge_reg #(.WIDTH(WIDTH)) u_rise (
    .clk (clk_p),
    .clr (rst),
    .en  (ce),
    .d   (pad_i),
    .q   (even_o)
  );

  // Odd beat: complementary rising edge, controls retimed from clk_p.
  ddr_rx_edge_reg #(.WIDTH(WIDTH)) u_fall (
    .clk (clk_n),
    .clr (rst_q),
    .en  (ce_q),
    .d   (pad_i),
    .q   (fall_q)
  );

  generate
    if (CAS_EFF) begin : g_cascade
      // Re-register the odd beat on the primary clock.
      ddr_rx_edge_reg #(.WIDTH(WIDTH)) u_realign (
        .clk (clk_p),
        .clr (rst),
        .en  (ce),
        .d   (fall_q),
        .q   (odd_o)
      );
    end else begin : g_direct
      assign odd_o = fall_q;
    end
  endgenerate

endmodule

// File: rtl/ddr_rx_align_chk.sv
module ddr_rx_align_chk #(
  parameter int WIDTH   = 4,
  parameter bit CASCADE = 1'b1
) (
  input logic             clk_p,
  input logic             clk_n,
  input logic             rst,
  input logic             ce,
  input logic             rst_q,
  input logic             ce_q,
  input logic [WIDTH-1:0] pad_i,
  input logic [WIDTH-1:0] fall_q,
  input logic [WIDTH-1:0] even_o,
  input logic [WIDTH-1:0] odd_o
);

  p_reset_clears_even_r1: assert property (@(posedge clk_p)
    rst |=> even_o == '0);

  p_reset_over_hold_r7: assert property (@(posedge clk_p)
    (rst && !ce) |=> even_o == '0);

  p_even_capture_r2: assert property (@(posedge clk_p) disable iff (rst)
    ce |=> even_o == $past(pad_i));

  p_even_hold_r6: assert property (@(posedge clk_p) disable iff (rst)
    !ce |=> $stable(even_o));

  p_fall_capture_r3: assert property (@(posedge clk_n) disable iff (rst_q)
    ce_q |=> fall_q == $past(pad_i));

  generate
    if (CASCADE) begin : g_cas
      p_odd_realign_r4: assert property (@(posedge clk_p) disable iff (rst)
        ce |=> odd_o == $past(fall_q));
      p_odd_hold_r6: assert property (@(posedge clk_p) disable iff (rst)
        !ce |=> $stable(odd_o));
      p_reset_clears_odd_r1: assert property (@(posedge clk_p)
        rst |=> odd_o == '0);
    end else begin : g_dir
      p_odd_direct_r3: assert property (@(posedge clk_n) disable iff (rst_q)
        ce_q |=> odd_o == $past(pad_i));
      p_odd_hold_r6: assert property (@(posedge clk_n) disable iff (rst_q)
        !ce_q |=> $stable(odd_o));
      p_reset_clears_odd_r1: assert property (@(posedge clk_n)
        rst_q |=> odd_o == '0);
    end
  endgenerate

endmodule

bind ddr_rx_align ddr_rx_align_chk #(
  .WIDTH   (WIDTH),
  .CASCADE (CAS_EFF)
) u_chk (
  .clk_p  (clk_p),
  .clk_n  (clk_n),
  .rst    (rst),
  .ce     (ce),
  .rst_q  (rst_q),
  .ce_q   (ce_q),
  .pad_i  (pad_i),
  .fall_q (fall_q),
  .even_o (even_o),
  .odd_o  (odd_o)
);

// File: tb/test_ddr_rx_align.sv
module test_ddr_rx_align;

  localparam int W = 4;

  logic         clk_p = 1'b0;
  logic         clk_n;
  logic         rst   = 1'b1;
  logic         ce    = 1'b0;
  logic [W-1:0] pad   = '0;

  logic [W-1:0] even_c, odd_c, even_d, odd_d, even_s, odd_s;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state, kept from the requirements
  logic [W-1:0] m_even, m_fall, m_cas;

  always #10 clk_p = ~clk_p;   // 50 MHz
  assign clk_n = ~clk_p;

  ddr_rx_align #(.WIDTH(W), .MODE(ddr_rx_pkg::REALIGN_CASCADE), .DIFF_INPUT(1'b1)) i_ddr_rx_align (
    .clk_p(clk_p), .clk_n(clk_n), .rst(rst), .ce(ce), .pad_i(pad),
    .even_o(even_c), .odd_o(odd_c));

  ddr_rx_align #(.WIDTH(W), .MODE(ddr_rx_pkg::REALIGN_DIRECT), .DIFF_INPUT(1'b1)) i_ddr_rx_align_dir (
    .clk_p(clk_p), .clk_n(clk_n), .rst(rst), .ce(ce), .pad_i(pad),
    .even_o(even_d), .odd_o(odd_d));

  ddr_rx_align #(.WIDTH(W), .MODE(ddr_rx_pkg::REALIGN_CASCADE), .DIFF_INPUT(1'b0)) i_ddr_rx_align_se (
    .clk_p(clk_p), .clk_n(clk_n), .rst(rst), .ce(ce), .pad_i(pad),
    .even_o(even_s), .odd_o(odd_s));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Starts 5 ns before a primary rising edge, ends 15 ns after it.
  task automatic step(input logic [W-1:0] e, input logic [W-1:0] o,
                      input logic c, input logic r, input string tag);
    pad = e; ce = c; rst = r;
    #10;
    pad = o;
    #10;
    if (r) begin
      m_even = '0; m_fall = '0; m_cas = '0;
    end else if (c) begin
      m_cas  = m_fall;
      m_even = e;
      m_fall = o;
    end
    chk($sformatf("%s R2 even cascade", tag), even_c, m_even);
    chk($sformatf("%s R2 even direct",  tag), even_d, m_even);
    chk($sformatf("%s R2 even single",  tag), even_s, m_even);
    chk($sformatf("%s R4 odd cascade",  tag), odd_c,  m_cas);
    chk($sformatf("%s R3 odd direct",   tag), odd_d,  m_fall);
    chk($sformatf("%s R5 odd single",   tag), odd_s,  m_fall);
  endtask

  task automatic t_reset;
    step(4'hF, 4'hA, 1'b1, 1'b1, "R1 reset");
    step(4'h5, 4'hC, 1'b1, 1'b1, "R1 reset");
  endtask

  task automatic t_count;
    for (int k = 0; k < 16; k++)
      step(4'(k), ~4'(k), 1'b1, 1'b0, "count");
  endtask

  task automatic t_walk;
    for (int i = 0; i < W; i++)
      step(4'(1 << i), 4'h0, 1'b1, 1'b0, "R8 walk-even");
    for (int i = 0; i < W; i++)
      step(4'h0, 4'(1 << i), 1'b1, 1'b0, "R8 walk-odd");
    step(4'h0, 4'h0, 1'b1, 1'b0, "R8 flush");
  endtask

  task automatic t_hold;
    step(4'h3, 4'h9, 1'b1, 1'b0, "R6 prime");
    step(4'h6, 4'hE, 1'b1, 1'b0, "R6 prime");
    for (int k = 0; k < 3; k++)
      step(4'(k + 10), 4'(k + 1), 1'b0, 1'b0, "R6 hold");
    step(4'hB, 4'h4, 1'b1, 1'b0, "R6 resume");
    step(4'h2, 4'h7, 1'b1, 1'b0, "R6 resume");
  endtask

  task automatic t_reset_hold;
    step(4'hD, 4'h1, 1'b1, 1'b0, "R7 prime");
    step(4'hE, 4'hB, 1'b0, 1'b1, "R7 reset-ce-low");
    step(4'h8, 4'h4, 1'b1, 1'b0, "R7 after");
    step(4'h1, 4'h2, 1'b1, 1'b0, "R7 after");
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    @(posedge clk_p);
    #15;
    t_reset();
    t_count();
    t_walk();
    t_hold();
    t_reset_hold();
    done = 1'b1;
    finish_run();
  end

endmodule